// File: doc/BRIEF.md
# Three-Bus Register Datapath with Memory Address and Data Registers

This block is the execution datapath of a small load/store processor. A register file of sixteen 32-bit registers is read onto two source buses, A and B, whose values are captured in two operand buffers. The ALU works on the buffered operands, a shifter follows it, and the shifted value travels on the result bus C back to a destination register. Register 15 is the program counter, so a branch is an ordinary register-to-register operation whose destination happens to be register 15.

Memory traffic goes through two dedicated registers. The memory address register (MAR) is loaded from the B bus. The memory data register (MDR) is loaded either from the A bus (store data) or from the external read data (load data). The MDR is never driven onto a register bus. A two-way select in front of the ALU's first operand picks the MDR instead of the A buffer, so a load result reaches its destination through the normal ALU and shifter path.

All selects and write enables come from a flat control word supplied every cycle by an outside sequencer. A typical operation takes two cycles. In the first cycle the operand buffers (and MAR or MDR when needed) are loaded. In the second cycle the destination write is committed.

Top module: `dp_core`

## Requirements
- R1: While reset is held, and until control acts after release, `mem_addr`, `mem_wdata`, `pc` and `flags` read zero, and every general register reads zero.
- R2: The operand buffers load the A and B bus values only on a clock edge where `buf_a_we` / `buf_b_we` is high. A later write to the source register does not change `c_bus` computed from the buffered operands.
- R3: With `alu_a_sel` = 1 the ALU's first operand is the MDR. With 0 it is the A buffer.
- R4: `alu_op` codes: 0 pass first operand, 1 pass second operand, 2 add, 3 subtract (first minus second), 4 multiply (low 32 bits), 5 compare (result is the difference). Codes 6 and 7 give zero.
- R5: `shift_op` codes: 0 no shift, 1 logical left, 2 logical right, 3 arithmetic right. The shift distance is `shift_amt`, and the shifter output is `c_bus`.
- R6: On an edge with `dest_we` high and a non-compare operation, register `dest_reg` takes `c_bus`. The new value can be read on the next cycle.
- R7: `pc` shows register 15. It changes only on a committed write with `dest_reg` = 15.
- R8: On a committed compare (`dest_we` with code 5), `flags` = {N,Z,C,V} from first minus second operand: C = no borrow, V = signed overflow. No register is written. At all other times `flags` holds.
- R9: `mem_addr` loads the B bus on an edge with `mar_we` high and holds otherwise.
- R10: `mem_wdata` loads the A bus (`mdr_src` = 0) or `mem_rdata` (`mdr_src` = 1) on an edge with `mdr_we` high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_idx | input | 4 | Register driven onto the A bus |
| b_idx | input | 4 | Register driven onto the B bus |
| buf_a_we | input | 1 | Load A buffer |
| buf_b_we | input | 1 | Load B buffer |
| mar_we | input | 1 | Load MAR from B bus |
| mdr_we | input | 1 | Load MDR |
| mdr_src | input | 1 | MDR source: 0 A bus, 1 memory read data |
| alu_a_sel | input | 1 | ALU first operand: 0 A buffer, 1 MDR |
| alu_op | input | 3 | ALU operation code |
| shift_op | input | 2 | Shifter mode |
| shift_amt | input | 5 | Shift distance |
| dest_idx | input | 4 | Destination register |
| dest_we | input | 1 | Commit result |
| mem_rdata | input | 32 | Data returned by memory |
| mem_addr | output | 32 | MAR contents |
| mem_wdata | output | 32 | MDR contents |
| c_bus | output | 32 | Shifted ALU result |
| pc | output | 32 | Register 15 |
| flags | output | 4 | {N,Z,C,V} |

## Verification
A stale or wrongly loaded operand buffer shows on `c_bus` in the very cycle the operation is committed. A wrong register-file entry shows only when that register is later driven through the buffers, so the bench reads back destinations and registers that should be unaffected. A bad MAR, MDR or flag update shows on its output at the next sample, one edge after the load. Hold checks in the following cycle catch spurious loads.

// File: rtl/dp_pkg.sv
package dp_pkg;
  typedef enum logic [2:0] {
    OP_PASS_A = 3'd0,
    OP_PASS_B = 3'd1,
    OP_ADD    = 3'd2,
    OP_SUB    = 3'd3,
    OP_MUL    = 3'd4,
    OP_CMP    = 3'd5
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_LSL  = 2'd1,
    SH_LSR  = 2'd2,
    SH_ASR  = 2'd3
  } shift_e;
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 16,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     ra_idx,
  input  logic [AW-1:0]     rb_idx,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] last_q
);
  logic [DATA_W-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic              en;
    logic [DATA_W-1:0] d;
    always_comb begin
      en = wr_en && (wr_idx == AW'(g));
      d  = en ? wr_data : regs_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= '0;
      else        regs_q[g] <= d;
    end
  end

  assign ra_data = regs_q[ra_idx];
  assign rb_data = regs_q[rb_idx];
  assign last_q  = regs_q[NREGS-1];
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [2:0]        op,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        cmp_flags
);
  logic [DATA_W:0]   diff_ext;
  logic [DATA_W-1:0] diff;
  logic [DATA_W-1:0] prod;

  always_comb begin
    diff_ext = {1'b0, opa} + {1'b0, ~opb} + {{DATA_W{1'b0}}, 1'b1};
    diff     = diff_ext[DATA_W-1:0];
    prod     = opa * opb;
    unique case (op)
      OP_PASS_A: result = opa;
      OP_PASS_B: result = opb;
      OP_ADD:    result = opa + opb;
      OP_SUB:    result = diff;
      OP_MUL:    result = prod;
      OP_CMP:    result = diff;
      default:   result = '0;
    endcase
    cmp_flags = {diff[DATA_W-1],
                 (diff == '0),
                 diff_ext[DATA_W],
                 (opa[DATA_W-1] != opb[DATA_W-1]) && (diff[DATA_W-1] != opa[DATA_W-1])};
  end
endmodule

// File: rtl/dp_shifter.sv
module dp_shifter
  import dp_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SW    = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        mode,
  input  logic [SW-1:0]     amt,
  output logic [DATA_W-1:0] dout
);
  always_comb begin
    unique case (mode)
      SH_LSL:  dout = din << amt;
      SH_LSR:  dout = din >> amt;
      SH_ASR:  dout = DATA_W'($signed(din) >>> amt);
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/dp_core.sv
module dp_core
  import dp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREGS  = 16,
  localparam int AW    = $clog2(NREGS),
  localparam int SW    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     a_idx,
  input  logic [AW-1:0]     b_idx,
  input  logic              buf_a_we,
  input  logic              buf_b_we,
  input  logic              mar_we,
  input  logic              mdr_we,
  input  logic              mdr_src,
  input  logic              alu_a_sel,
  input  logic [2:0]        alu_op,
  input  logic [1:0]        shift_op,
  input  logic [SW-1:0]     shift_amt,
  input  logic [AW-1:0]     dest_idx,
  input  logic              dest_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] c_bus,
  output logic [DATA_W-1:0] pc,
  output logic [3:0]        flags
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [DATA_W-1:0] a_bus, b_bus;
  logic [DATA_W-1:0] buf_a_q, buf_a_d, buf_b_q, buf_b_d;
  logic [DATA_W-1:0] mar_q, mar_d, mdr_q, mdr_d;
  logic [3:0]        flags_q, flags_d;
  logic [DATA_W-1:0] alu_opa, alu_res;
  logic [3:0]        alu_flags;
  logic              is_cmp, rf_we;

  assign is_cmp = (alu_op == OP_CMP);
  assign rf_we  = dest_we && !is_cmp;

  dp_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ra_idx  (a_idx),
    .rb_idx  (b_idx),
    .ra_data (a_bus),
    .rb_data (b_bus),
    .wr_en   (rf_we),
    .wr_idx  (dest_idx),
    .wr_data (c_bus),
    .last_q  (pc)
  );

  assign alu_opa = alu_a_sel ? mdr_q : buf_a_q;

  dp_alu #(.DATA_W(DATA_W)) u_alu (
    .opa       (alu_opa),
    .opb       (buf_b_q),
    .op        (alu_op),
    .result    (alu_res),
    .cmp_flags (alu_flags)
  );

  dp_shifter #(.DATA_W(DATA_W)) u_shf (
    .din  (alu_res),
    .mode (shift_op),
    .amt  (shift_amt),
    .dout (c_bus)
  );

  always_comb begin
    buf_a_d = buf_a_we ? a_bus : buf_a_q;
    buf_b_d = buf_b_we ? b_bus : buf_b_q;
    mar_d   = mar_we   ? b_bus : mar_q;
    mdr_d   = mdr_q;
    if (mdr_we) mdr_d = mdr_src ? mem_rdata : a_bus;
    flags_d = (dest_we && is_cmp) ? alu_flags : flags_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      buf_a_q <= '0;
      buf_b_q <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      flags_q <= '0;
    end else begin
      buf_a_q <= buf_a_d;
      buf_b_q <= buf_b_d;
      mar_q   <= mar_d;
      mdr_q   <= mdr_d;
      flags_q <= flags_d;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign flags     = flags_q;
endmodule

// File: rtl/dp_core_checker.sv
module dp_core_checker #(
  parameter int DATA_W = 32,
  parameter int AW     = 4
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              mar_we,
  input logic              mdr_we,
  input logic              mdr_src,
  input logic              dest_we,
  input logic [2:0]        alu_op,
  input logic [AW-1:0]     dest_idx,
  input logic [DATA_W-1:0] a_bus,
  input logic [DATA_W-1:0] b_bus,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] c_bus,
  input logic [DATA_W-1:0] pc,
  input logic [3:0]        flags
);
  localparam logic [2:0]    CMP_CODE = 3'd5;
  localparam logic [AW-1:0] PC_IDX   = {AW{1'b1}};

  p_mar_load_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    mar_we |=> mem_addr == $past(b_bus));
  p_mar_hold_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    !mar_we |=> $stable(mem_addr));
  p_mdr_mem_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    (mdr_we && mdr_src) |=> mem_wdata == $past(mem_rdata));
  p_mdr_bus_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    (mdr_we && !mdr_src) |=> mem_wdata == $past(a_bus));
  p_mdr_hold_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    !mdr_we |=> $stable(mem_wdata));
  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    !(dest_we && alu_op == CMP_CODE) |=> $stable(flags));
  p_pc_hold_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    !(dest_we && dest_idx == PC_IDX && alu_op != CMP_CODE) |=> $stable(pc));
  p_pc_write_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (dest_we && dest_idx == PC_IDX && alu_op != CMP_CODE) |=> pc == $past(c_bus));
endmodule

bind dp_core dp_core_checker #(.DATA_W(DATA_W), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .mar_we    (mar_we),
  .mdr_we    (mdr_we),
  .mdr_src   (mdr_src),
  .dest_we   (dest_we),
  .alu_op    (alu_op),
  .dest_idx  (dest_idx),
  .a_bus     (a_bus),
  .b_bus     (b_bus),
  .mem_rdata (mem_rdata),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .c_bus     (c_bus),
  .pc        (pc),
  .flags     (flags)
);

// File: tb/dp_core_bench.sv
module dp_core_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  a_idx, b_idx, dest_idx;
  logic        buf_a_we, buf_b_we, mar_we, mdr_we, mdr_src, alu_a_sel, dest_we;
  logic [2:0]  alu_op;
  logic [1:0]  shift_op;
  logic [4:0]  shift_amt;
  logic [31:0] mem_rdata, mem_addr, mem_wdata, c_bus, pc;
  logic [3:0]  flags;

  always #10 clk = ~clk;

  dp_core u_dp_core (
    .clk(clk), .rst_n(rst_n), .a_idx(a_idx), .b_idx(b_idx),
    .buf_a_we(buf_a_we), .buf_b_we(buf_b_we), .mar_we(mar_we), .mdr_we(mdr_we),
    .mdr_src(mdr_src), .alu_a_sel(alu_a_sel), .alu_op(alu_op), .shift_op(shift_op),
    .shift_amt(shift_amt), .dest_idx(dest_idx), .dest_we(dest_we),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .c_bus(c_bus), .pc(pc), .flags(flags)
  );

  typedef enum int {K_CBUS, K_ADDR, K_WDATA, K_PC, K_FLAGS} kind_e;
  typedef struct {
    kind_e       kind;
    logic [31:0] exp;
    string       req;
    int          due;
  } item_t;

  item_t       sb[$];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;
  logic [31:0] m_r [16];
  logic [31:0] m_ba, m_bb, m_mdr;
  logic [3:0]  m_flags;

  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard driver side
  task automatic push(kind_e k, logic [31:0] v, string req);
    item_t e;
    e.kind = k; e.exp = v; e.req = req; e.due = cyc + 1;
    sb.push_back(e);
  endtask

  // scoreboard monitor side
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t e;
      logic [31:0] act;
      e = sb.pop_front();
      case (e.kind)
        K_CBUS:  act = c_bus;
        K_ADDR:  act = mem_addr;
        K_WDATA: act = mem_wdata;
        K_PC:    act = pc;
        default: act = {28'd0, flags};
      endcase
      n_chk++;
      if (act !== e.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", e.req, e.kind, act, e.exp);
      end
    end
  end

  function automatic logic [31:0] alu_m(logic [31:0] a, logic [31:0] b, logic [2:0] op);
    case (op)
      3'd0: return a;
      3'd1: return b;
      3'd2: return a + b;
      3'd3, 3'd5: return a - b;
      3'd4: return a * b;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] shf_m(logic [31:0] v, logic [1:0] m, logic [4:0] n);
    case (m)
      2'd1: return v << n;
      2'd2: return v >> n;
      2'd3: return 32'($signed(v) >>> n);
      default: return v;
    endcase
  endfunction

  function automatic logic [3:0] cmp_m(logic [31:0] a, logic [31:0] b);
    logic [31:0] d;
    d = a - b;
    return {d[31], d == 32'd0, a >= b, (a[31] != b[31]) && (d[31] != a[31])};
  endfunction

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  task automatic clr();
    buf_a_we = 0; buf_b_we = 0; mar_we = 0; mdr_we = 0; mdr_src = 0;
    alu_a_sel = 0; alu_op = 0; shift_op = 0; shift_amt = 0; dest_we = 0;
    a_idx = 0; b_idx = 0; dest_idx = 0;
  endtask

  // load path: memory -> MDR -> ALU (first operand select) -> register
  task automatic ld(int r, logic [31:0] v);
    clr(); mem_rdata = v; mdr_we = 1; mdr_src = 1;
    push(K_WDATA, v, "R10");
    tick(); m_mdr = v;
    clr(); alu_a_sel = 1; alu_op = 3'd0; dest_idx = 4'(r); dest_we = 1;
    push(K_CBUS, v, "R3");
    m_r[r] = v;
    push(K_PC, m_r[15], "R7");
    tick();
  endtask

  task automatic ph1(int ra, int rb);
    clr(); a_idx = 4'(ra); b_idx = 4'(rb); buf_a_we = 1; buf_b_we = 1;
    tick(); m_ba = m_r[ra]; m_bb = m_r[rb];
  endtask

  task automatic ph2(logic [2:0] op, logic [1:0] sh, logic [4:0] n, int rd,
                     bit we, bit asel, string req);
    logic [31:0] a, res;
    clr(); alu_op = op; shift_op = sh; shift_amt = n; dest_idx = 4'(rd);
    dest_we = we; alu_a_sel = asel;
    a = asel ? m_mdr : m_ba;
    res = shf_m(alu_m(a, m_bb, op), sh, n);
    push(K_CBUS, res, req);
    if (we && op == 3'd5) m_flags = cmp_m(a, m_bb);
    if (we && op != 3'd5) m_r[rd] = res;
    push(K_FLAGS, {28'd0, m_flags}, "R8");
    push(K_PC, m_r[15], "R7");
    tick();
  endtask

  task automatic op(int ra, int rb, logic [2:0] o, logic [1:0] sh, logic [4:0] n,
                    int rd, bit we, string req);
    ph1(ra, rb);
    ph2(o, sh, n, rd, we, 1'b0, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_r[i] = 32'd0;
    m_ba = 0; m_bb = 0; m_mdr = 0; m_flags = 0;
    clr(); mem_rdata = 32'h1234_5678; rst_n = 0;
    tick(); tick();
    // R1: reset state
    push(K_ADDR, 32'd0, "R1");
    push(K_WDATA, 32'd0, "R1");
    push(K_PC, 32'd0, "R1");
    push(K_FLAGS, 32'd0, "R1");
    tick();
    rst_n = 1;
    tick(); tick(); tick();
    push(K_CBUS, 32'd0, "R1");
    tick();
    op(5, 6, 3'd2, 2'd0, 0, 0, 0, "R1 regs zero");

    ld(1, 32'd100);
    ld(2, 32'd7);
    // R4: arithmetic codes, R6 destination writes
    op(1, 2, 3'd2, 2'd0, 0, 3, 1, "R4 add");
    op(1, 2, 3'd3, 2'd0, 0, 4, 1, "R4 sub");
    op(1, 2, 3'd4, 2'd0, 0, 5, 1, "R4 mul");
    op(1, 2, 3'd1, 2'd0, 0, 6, 1, "R4 pass second");
    op(1, 2, 3'd6, 2'd0, 0, 0, 0, "R4 unused code");
    op(3, 0, 3'd0, 2'd0, 0, 0, 0, "R6 readback r3");
    op(4, 5, 3'd2, 2'd0, 0, 0, 0, "R6 readback r4+r5");
    // R5: shifter modes
    op(1, 0, 3'd0, 2'd1, 4, 7, 1, "R5 lsl");
    ld(8, 32'h8000_0010);
    op(8, 0, 3'd0, 2'd3, 4, 9, 1, "R5 asr");
    op(8, 0, 3'd0, 2'd2, 4, 10, 1, "R5 lsr");
    op(8, 0, 3'd0, 2'd1, 31, 0, 0, "R5 lsl max");
    // R8: compare
    op(2, 1, 3'd5, 2'd0, 0, 11, 1, "R8 cmp less");
    op(11, 0, 3'd0, 2'd0, 0, 0, 0, "R8 no dest write");
    op(1, 1, 3'd5, 2'd0, 0, 11, 1, "R8 cmp equal");
    ld(12, 32'h7FFF_FFFF);
    op(12, 8, 3'd5, 2'd0, 0, 11, 1, "R8 cmp overflow");
    op(1, 2, 3'd2, 2'd0, 0, 13, 1, "R8 flags hold");
    op(1, 2, 3'd5, 2'd0, 0, 11, 0, "R8 cmp uncommitted");
    // R2: buffer holds operand across a write to its source
    ph1(1, 2);
    ld(1, 32'd5);
    ph2(3'd2, 2'd0, 0, 14, 1, 1'b0, "R2 buffer hold");
    op(1, 14, 3'd0, 2'd0, 0, 0, 0, "R2 new r1");
    // R9: MAR
    clr(); b_idx = 2; mar_we = 1; push(K_ADDR, m_r[2], "R9 load"); tick();
    clr(); b_idx = 1; push(K_ADDR, m_r[2], "R9 hold"); tick();
    // R10: MDR from A bus, then hold, then R3 select into ALU
    clr(); a_idx = 3; mdr_we = 1; mdr_src = 0; push(K_WDATA, m_r[3], "R10 bus");
    tick(); m_mdr = m_r[3];
    clr(); a_idx = 5; mem_rdata = 32'hDEAD_BEEF; push(K_WDATA, m_mdr, "R10 hold"); tick();
    ph1(9, 2);
    ph2(3'd2, 2'd0, 0, 0, 0, 1'b1, "R3 mdr operand");
    ph2(3'd2, 2'd0, 0, 0, 0, 1'b0, "R3 buffer operand");
    // R7: branch writes
    ld(15, 32'h0000_0400);
    op(15, 2, 3'd2, 2'd0, 0, 15, 1, "R7 branch add");
    op(1, 2, 3'd5, 2'd0, 0, 15, 1, "R7 cmp to pc");
    op(1, 2, 3'd2, 2'd0, 0, 3, 1, "R7 other dest");

    tick(); tick();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule